// File: doc/BRIEF.md
# Composite Sync Polarity Normalizer and Separator

This block receives one digital horizontal or composite sync line, oversampled by the system clock, and turns it into clean timing events. The active level of the input is not known in advance. The block measures the level of the input over a window of lines, decides which level is the active one, and normalizes the stream to active-high. Pulses that are too short are treated as glitches. Each surviving leading edge becomes a one-cycle horizontal strobe with a fixed latency.

The block measures every line from one accepted leading edge to the next. It compares the active time inside that span with the span itself. A line whose active share is above one quarter counts as a vertical-interval line, such as a broad serration pulse. With hysteresis, these lines drive a vertical sync output and an inhibit that tells the downstream phase comparator to hold its update. Pulses that arrive well before the expected line period are dropped, which removes the half-line equalizing pulses from the horizontal stream.

The block also checks its own detection. When vertical sync has not been seen for a set number of lines, it clears its vertical-present flag and runs the polarity measurement again. When the measured polarity flips, it restarts the line classifier.

Top module: `csync_separator`

## Requirements
- R1: While rst_n is low, every output is 0.
- R2: After POL_LINES rising edges of the synchronized input, pol_valid is 1. pol_neg is 1 exactly when the input spent more cycles high than low in that window, meaning the active level is low.
- R3: Each accepted sync pulse gives hs_strobe high for exactly one cycle. The strobe falls MIN_W+3 clock edges after the first edge that samples the new active level on sync_in, and this holds for both polarities.
- R4: A pulse whose active level lasts fewer than MIN_W cycles produces no hs_strobe.
- R5: A qualified pulse that arrives less than three quarters of the last measured line period after the previous accepted pulse is dropped and produces no hs_strobe. Half-line equalizing pulses fall into this case.
- R6: vs_out rises in the same cycle as the hs_strobe that closes the second consecutive line whose active cycles times 4 exceed the line length in cycles.
- R7: vs_out falls in the same cycle as the hs_strobe that closes the second consecutive line that is not high-duty.
- R8: pc_inhibit equals vs_out in every cycle.
- R9: v_present rises together with vs_out. It falls at the VMISS_LINES-th accepted line after that rise if vs_out has not risen again, and then pol_valid clears so that polarity detection runs again.
- R10: When a new polarity decision differs from the previous valid one, the classifier restarts. On the next cycle vs_out and v_present are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Asynchronous horizontal or composite sync, either polarity |
| hs_strobe | output | 1 | One-cycle strobe per accepted horizontal leading edge |
| vs_out | output | 1 | Extracted vertical sync, active high |
| pc_inhibit | output | 1 | Phase-comparator hold request during vertical sync |
| pol_neg | output | 1 | Detected polarity, 1 when sync is active low |
| pol_valid | output | 1 | Polarity decision is valid |
| v_present | output | 1 | Vertical sync seen recently |

## Verification
An input change driven at a falling clock edge shows up as hs_strobe MIN_W+3 rising edges later. The driver stores that cycle number, with the vertical level expected from its own two-line hysteresis model, in the scoreboard queue. The monitor samples on falling edges and pops one entry per strobe. It compares the cycle number, vs_out and pc_inhibit, so vertical changes are checked in the same cycle as the strobe that closes the deciding line. Glitch and equalizing lines are checked by counting strobes over one whole line. v_present and pol_valid are read at line boundaries: one line before and at the VMISS_LINES-th line after the vertical rise.

// File: rtl/csync_pkg.sv
package csync_pkg;

  // True when the active cycles of a line exceed a quarter of its length.
  function automatic logic duty_over_quarter(input logic [31:0] act_cyc,
                                             input logic [31:0] line_cyc);
    logic [33:0] act_x4;
    act_x4 = {act_cyc, 2'b00};
    return act_x4 > {2'b00, line_cyc};
  endfunction

  // True when an edge comes before three quarters of the reference period.
  function automatic logic edge_is_early(input logic [31:0] gap_cyc,
                                         input logic [31:0] per_cyc);
    logic [33:0] gap_x4;
    logic [33:0] per_x3;
    gap_x4 = {gap_cyc, 2'b00};
    per_x3 = {2'b00, per_cyc} + {1'b0, per_cyc, 1'b0};
    return gap_x4 < per_x3;
  endfunction

  // True when the high level occupied more than half of the window.
  function automatic logic high_dominates(input logic [31:0] hi_cyc,
                                          input logic [31:0] all_cyc);
    logic [32:0] hi_x2;
    hi_x2 = {hi_cyc, 1'b0};
    return hi_x2 > {1'b0, all_cyc};
  endfunction

endpackage

// File: rtl/csync_pol_detect.sv
module csync_pol_detect
  import csync_pkg::*;
#(
  parameter int POL_LINES = 16,
  parameter int ACC_W     = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  input  logic restart,
  output logic sync_s,
  output logic pol_neg,
  output logic pol_valid,
  output logic pol_chg
);
  localparam int LC_W = $clog2(POL_LINES + 1);

  logic             meta_q, sync_q, sync_d;
  logic [LC_W-1:0]  line_cnt;
  logic [ACC_W-1:0] hi_cnt, tot_cnt;

  logic rise_ev, window_done, acc_full, neg_now;

  assign sync_s      = sync_q;
  assign rise_ev     = sync_q & ~sync_d;
  assign window_done = rise_ev && (line_cnt == LC_W'(POL_LINES - 1));
  assign acc_full    = &tot_cnt;
  assign neg_now     = high_dominates(32'(hi_cnt), 32'(tot_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q    <= 1'b0;
      sync_q    <= 1'b0;
      sync_d    <= 1'b0;
      line_cnt  <= '0;
      hi_cnt    <= '0;
      tot_cnt   <= '0;
      pol_neg   <= 1'b0;
      pol_valid <= 1'b0;
      pol_chg   <= 1'b0;
    end else begin
      meta_q  <= sync_raw;
      sync_q  <= meta_q;
      sync_d  <= sync_q;
      pol_chg <= 1'b0;
      if (restart) begin
        line_cnt  <= '0;
        hi_cnt    <= '0;
        tot_cnt   <= '0;
        pol_valid <= 1'b0;
      end else begin
        if (rise_ev)
          line_cnt <= window_done ? '0 : line_cnt + 1'b1;
        if (window_done) begin
          hi_cnt    <= '0;
          tot_cnt   <= '0;
          pol_neg   <= neg_now;
          pol_valid <= 1'b1;
          pol_chg   <= pol_valid && (neg_now != pol_neg);
        end else if (!acc_full) begin
          tot_cnt <= tot_cnt + 1'b1;
          hi_cnt  <= hi_cnt + ACC_W'(sync_q);
        end
      end
    end
  end
endmodule

// File: rtl/csync_pulse_qual.sv
module csync_pulse_qual #(
  parameter int MIN_W = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic lead_q
);
  localparam int RW = $clog2(MIN_W + 1);

  logic [RW-1:0] run_len;
  logic          run_full, hit_min;

  assign run_full = (run_len == RW'(MIN_W));
  assign hit_min  = act && (run_len == RW'(MIN_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
      lead_q  <= 1'b0;
    end else begin
      if (!act)
        run_len <= '0;
      else if (!run_full)
        run_len <= run_len + 1'b1;
      lead_q <= hit_min;
    end
  end
endmodule

// File: rtl/csync_line_class.sv
module csync_line_class
  import csync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int VMISS_LINES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic lead_q,
  input  logic restart,
  output logic hs_strobe,
  output logic vs_out,
  output logic v_present,
  output logic vloss
);
  localparam int VC_W = $clog2(VMISS_LINES + 1);

  logic [CNT_W-1:0] elapsed, per_last, act_acc;
  logic             have_edge, per_ok;
  logic [1:0]       hi_run, lo_run;
  logic [VC_W-1:0]  vcount;

  logic timeout, drop_eq, accept, classify, line_high, vs_set;

  assign timeout   = &elapsed;
  assign drop_eq   = lead_q && per_ok && edge_is_early(32'(elapsed), 32'(per_last));
  assign accept    = lead_q && !drop_eq;
  assign classify  = accept && have_edge && !timeout;
  assign line_high = duty_over_quarter(32'(act_acc), 32'(elapsed));
  assign vs_set    = classify && line_high && (hi_run != 2'd0) && !vs_out;

  // line timing: period, active count, equalizer rejection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed   <= '0;
      per_last  <= '0;
      act_acc   <= '0;
      have_edge <= 1'b0;
      per_ok    <= 1'b0;
      hs_strobe <= 1'b0;
    end else begin
      hs_strobe <= 1'b0;
      if (restart) begin
        elapsed   <= '0;
        act_acc   <= '0;
        have_edge <= 1'b0;
        per_ok    <= 1'b0;
      end else begin
        if (!timeout) elapsed <= elapsed + 1'b1;
        if (!(&act_acc)) act_acc <= act_acc + CNT_W'(act);
        if (timeout) begin
          have_edge <= 1'b0;
          per_ok    <= 1'b0;
        end
        if (accept) begin
          hs_strobe <= 1'b1;
          have_edge <= 1'b1;
          elapsed   <= CNT_W'(1);
          act_acc   <= CNT_W'(act);
        end
        if (classify) begin
          per_last <= elapsed;
          per_ok   <= 1'b1;
        end
      end
    end
  end

  // two-line hysteresis for vertical sync, vertical presence watch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run    <= '0;
      lo_run    <= '0;
      vs_out    <= 1'b0;
      v_present <= 1'b0;
      vcount    <= '0;
      vloss     <= 1'b0;
    end else begin
      vloss <= 1'b0;
      if (restart) begin
        hi_run    <= '0;
        lo_run    <= '0;
        vs_out    <= 1'b0;
        v_present <= 1'b0;
        vcount    <= '0;
      end else begin
        if (classify) begin
          if (line_high) begin
            lo_run <= '0;
            if (hi_run != 2'd2) hi_run <= hi_run + 1'b1;
            if (hi_run != 2'd0) vs_out <= 1'b1;
          end else begin
            hi_run <= '0;
            if (lo_run != 2'd2) lo_run <= lo_run + 1'b1;
            if (lo_run != 2'd0) vs_out <= 1'b0;
          end
        end
        if (vs_set) begin
          v_present <= 1'b1;
          vcount    <= '0;
        end else if (accept && v_present) begin
          if (vcount == VC_W'(VMISS_LINES - 1)) begin
            v_present <= 1'b0;
            vloss     <= 1'b1;
          end else begin
            vcount <= vcount + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/csync_separator.sv
module csync_separator #(
  parameter int MIN_W       = 35,
  parameter int POL_LINES   = 16,
  parameter int ACC_W       = 20,
  parameter int CNT_W       = 16,
  parameter int VMISS_LINES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic hs_strobe,
  output logic vs_out,
  output logic pc_inhibit,
  output logic pol_neg,
  output logic pol_valid,
  output logic v_present
);
  logic sync_s, pol_chg, vloss, act, lead_q, cls_restart;

  assign act         = pol_valid & (sync_s ^ pol_neg);
  assign cls_restart = pol_chg | vloss;
  assign pc_inhibit  = vs_out;

  csync_pol_detect #(.POL_LINES(POL_LINES), .ACC_W(ACC_W)) pol_i (
    .clk(clk), .rst_n(rst_n), .sync_raw(sync_in), .restart(vloss),
    .sync_s(sync_s), .pol_neg(pol_neg), .pol_valid(pol_valid), .pol_chg(pol_chg)
  );

  csync_pulse_qual #(.MIN_W(MIN_W)) qual_i (
    .clk(clk), .rst_n(rst_n), .act(act), .lead_q(lead_q)
  );

  csync_line_class #(.CNT_W(CNT_W), .VMISS_LINES(VMISS_LINES)) cls_i (
    .clk(clk), .rst_n(rst_n), .act(act), .lead_q(lead_q), .restart(cls_restart),
    .hs_strobe(hs_strobe), .vs_out(vs_out), .v_present(v_present), .vloss(vloss)
  );
endmodule

// File: rtl/csync_separator_chk.sv
module csync_separator_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_strobe,
  input logic vs_out,
  input logic v_present,
  input logic pol_neg,
  input logic pol_valid,
  input logic lead_q,
  input logic cls_restart
);
  a_r3_hs_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hs_strobe |=> !hs_strobe);

  a_r4_hs_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
    hs_strobe |-> $past(lead_q));

  a_r6_vs_rise_on_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_out) |-> hs_strobe);

  a_r7_vs_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_out) |-> (hs_strobe || $past(cls_restart)));

  a_r9_vp_rise_with_vs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_present) |-> $rose(vs_out));

  a_r10_flip_clears_vs: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_valid && $past(pol_valid) && (pol_neg != $past(pol_neg))) |=> (!vs_out && !v_present));
endmodule

bind csync_separator csync_separator_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hs_strobe(hs_strobe), .vs_out(vs_out),
  .v_present(v_present), .pol_neg(pol_neg), .pol_valid(pol_valid),
  .lead_q(lead_q), .cls_restart(cls_restart)
);

// File: tb/csync_separator_tb.sv
module csync_separator_tb_top;
  localparam int MIN_W = 35;
  localparam int POLN  = 16;
  localparam int VMISS = 24;
  localparam int LINE  = 640;
  localparam int NPW   = 64;
  localparam int WPW   = 224;
  localparam int EPW   = 40;
  localparam int GPW   = 20;
  localparam int GPOS  = 256;

  typedef enum {K_NORM, K_WIDE, K_EQ, K_GLITCH} kind_t;
  typedef struct { int at; logic vs; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b0;
  logic hs_strobe, vs_out, pc_inhibit, pol_neg, pol_valid, v_present;

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  csync_separator #(.MIN_W(MIN_W), .POL_LINES(POLN), .VMISS_LINES(VMISS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .hs_strobe(hs_strobe),
    .vs_out(vs_out), .pc_inhibit(pc_inhibit), .pol_neg(pol_neg),
    .pol_valid(pol_valid), .v_present(v_present)
  );

  exp_t sbq[$];
  exp_t got;
  int   checks = 0, errors = 0, hs_seen = 0, line_idx = 0, vr_line = -1;
  bit   sb_en = 0, neg = 0, last_hi = 0, last2_hi = 0;
  logic m_vs = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int actual, input int expct);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expct);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: pops one expected item per strobe
  always @(negedge clk) begin
    if (rst_n && hs_strobe) begin
      hs_seen++;
      if (sb_en) begin
        if (sbq.size() == 0) begin
          chk(0, "R5", "unexpected hs_strobe at cycle", cyc, -1);
        end else begin
          got = sbq.pop_front();
          chk(cyc == got.at, "R3", "hs_strobe cycle", cyc, got.at);
          chk(vs_out == got.vs, "R6,R7", "vs_out at line strobe", int'(vs_out), int'(got.vs));
          chk(pc_inhibit == vs_out, "R8", "pc_inhibit vs vs_out", int'(pc_inhibit), int'(vs_out));
        end
      end
    end
  end

  task automatic model_reset();
    last_hi = 0; last2_hi = 0; m_vs = 1'b0;
    sbq.delete();
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one line starting at a falling edge
  task automatic drive_line(input kind_t k);
    logic a, nv;
    int   w;
    a = ~neg;
    line_idx++;
    nv = (last_hi && last2_hi) ? 1'b1 : ((!last_hi && !last2_hi) ? 1'b0 : m_vs);
    if (sb_en) begin
      if (nv && !m_vs) vr_line = line_idx;
      sbq.push_back('{at: cyc + MIN_W + 3, vs: nv});
    end
    m_vs = nv;
    last2_hi = last_hi;
    last_hi  = (k == K_WIDE);
    w = (k == K_WIDE) ? WPW : ((k == K_EQ) ? EPW : NPW);
    sync_in = a;
    hold(w);
    sync_in = ~a;
    if (k == K_EQ) begin
      hold(LINE / 2 - EPW);
      sync_in = a;  hold(EPW);
      sync_in = ~a; hold(LINE / 2 - EPW);
    end else if (k == K_GLITCH) begin
      hold(GPOS - NPW);
      sync_in = a;  hold(GPW);
      sync_in = ~a; hold(LINE - GPOS - GPW);
    end else begin
      hold(LINE - w);
    end
  endtask

  task automatic lines(input kind_t k, input int n);
    for (int i = 0; i < n; i++) drive_line(k);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
    summary();
    $finish;
  end

  initial begin
    int h0;
    hold(5);
    chk({hs_strobe, vs_out, pc_inhibit, pol_neg, pol_valid, v_present} == 6'b0,
        "R1", "outputs in reset", int'({hs_strobe, vs_out, pc_inhibit, pol_neg, pol_valid, v_present}), 0);
    rst_n = 1'b1;
    hold(3);

    // phase A: positive sync
    lines(K_NORM, 20);
    chk(pol_valid == 1'b1, "R2", "pol_valid positive", int'(pol_valid), 1);
    chk(pol_neg == 1'b0, "R2", "pol_neg positive", int'(pol_neg), 0);
    model_reset();
    sb_en = 1;
    lines(K_NORM, 3);
    h0 = hs_seen; drive_line(K_GLITCH);
    chk(hs_seen - h0 == 1, "R4", "strobes in glitch line", hs_seen - h0, 1);
    for (int i = 0; i < 2; i++) begin
      h0 = hs_seen; drive_line(K_EQ);
      chk(hs_seen - h0 == 1, "R5", "strobes in equalizing line", hs_seen - h0, 1);
    end
    lines(K_NORM, 2);
    lines(K_WIDE, 4);
    chk(vs_out == 1'b1, "R6", "vs_out during vertical", int'(vs_out), 1);
    chk(v_present == 1'b1, "R9", "v_present after vertical", int'(v_present), 1);
    lines(K_NORM, 3);
    chk(vs_out == 1'b0, "R7", "vs_out after normal lines", int'(vs_out), 0);
    chk(pc_inhibit == 1'b0, "R8", "pc_inhibit after vertical", int'(pc_inhibit), 0);
    sb_en = 0;
    chk(sbq.size() == 0, "R3", "pending strobes phase A", sbq.size(), 0);

    // phase C: vertical missing
    while (line_idx < vr_line + VMISS - 1) drive_line(K_NORM);
    chk(v_present == 1'b1, "R9", "v_present one line before limit", int'(v_present), 1);
    drive_line(K_NORM);
    chk(v_present == 1'b0, "R9", "v_present at limit", int'(v_present), 0);
    chk(pol_valid == 1'b0, "R9", "polarity rerun started", int'(pol_valid), 0);
    lines(K_NORM, 20);
    chk(pol_valid == 1'b1, "R2", "pol_valid after rerun", int'(pol_valid), 1);

    // phase B: negative sync, polarity flip
    neg = 1; sync_in = 1'b1;
    lines(K_NORM, 40);
    chk(pol_valid == 1'b1, "R2", "pol_valid negative", int'(pol_valid), 1);
    chk(pol_neg == 1'b1, "R2", "pol_neg negative", int'(pol_neg), 1);
    chk(vs_out == 1'b0 && v_present == 1'b0, "R10", "vertical state after flip",
        int'({vs_out, v_present}), 0);
    model_reset();
    sb_en = 1;
    lines(K_NORM, 3);
    lines(K_WIDE, 3);
    chk(vs_out == 1'b1, "R6", "vs_out negative vertical", int'(vs_out), 1);
    lines(K_NORM, 3);
    chk(vs_out == 1'b0, "R7", "vs_out negative after vertical", int'(vs_out), 0);
    hold(10);
    sb_en = 0;
    chk(sbq.size() == 0, "R3", "pending strobes phase B", sbq.size(), 0);

    summary();
    $finish;
  end
endmodule